// File: doc/BRIEF.md
# Flash Boot Image Loader

After a power-up or board reset, this block decides whether a byte-wide parallel flash holds an FPGA configuration image. If it does, the block streams that image into an 8-bit configuration port. It first reads the leading bytes of the selected image region and compares them with a fixed sync word. When they match, it walks the flash with its own address counter and hands each following byte to the target with a one-cycle write strobe. It stops when a set number of bytes has gone out or when the target signals that it is configured.

Two images share the flash and differ only in the top address bit. A board jumper selects between them, so a known-good default image stays available if the secondary one is damaged. If the sync word is missing, for example on a blank flash, the block issues no configuration writes. It releases the flash and raises a programming-mode flag that enables a separate command interpreter, which then writes a new image.

Every flash read keeps chip select and output enable high for a fixed number of cycles. This gives slow flash parts time to answer, and the byte is sampled on the last cycle of that window.

Top module: `cfgld_top`

## Requirements
- R1: While reset is held, `cfgWrite`, `configDone`, `programmingMode`, `flashCs` and `flashOe` are low. The first read after reset addresses offset 0 of the selected image region.
- R2: The bytes at offsets 0 to SYNC_BYTES-1 are compared, in offset order, with SYNC_WORD taken most significant byte first. With the default 0xAA995566 this is 0xAA, 0x99, 0x55, 0x66.
- R3: On the first sync byte that differs, `programmingMode` goes high and stays high. No `cfgWrite` is issued and the flash is not read again, so a mismatch at offset k costs exactly (k+1)*READ_WAIT read cycles.
- R4: After a full match, the bytes from offset SYNC_BYTES upward are forwarded in increasing address order. During each `cfgWrite` pulse, `cfgData` equals the flash byte at the current `flashAddr`, and the low 24 address bits step by one after each pulse.
- R5: `jumperIn` is sampled once, on the first clock after reset. A value of 1 (jumper inserted) makes `flashAddr[24]` 0, the default image; a value of 0 makes it 1, the secondary image. Later changes have no effect.
- R6: Each read holds `flashCs` and `flashOe` high for exactly READ_WAIT cycles. A streamed byte's strobe follows its read at once, so consecutive strobes are READ_WAIT+1 cycles apart, and the first strobe comes (SYNC_BYTES+1)*READ_WAIT cycles after the first read cycle.
- R7: `flashCs` and `flashOe` are high only during read cycles. They are never high in the same cycle as `cfgWrite`, and never while `configDone` or `programmingMode` is high.
- R8: After STREAM_BYTES strobes, `configDone` rises in the next cycle and stays high, and no further strobe or read occurs.
- R9: While streaming, a high `cfgDoneIn` ends the transfer. A strobe in that same cycle still counts, no further strobe follows, and `configDone` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jumperIn | input | 1 | Image select jumper, 1 = inserted (default image) |
| flashAddr | output | 25 | Flash byte address; bit 24 selects the image |
| flashCs | output | 1 | Flash chip select, active high |
| flashOe | output | 1 | Flash output enable, active high |
| flashData | input | 8 | Flash read data |
| cfgData | output | 8 | Configuration byte to the target |
| cfgWrite | output | 1 | One-cycle configuration write strobe |
| cfgDoneIn | input | 1 | Target reports configuration complete |
| configDone | output | 1 | Loading finished, held high |
| programmingMode | output | 1 | No valid image; programming mode enabled, held high |

## Verification
The two events that can meet in one cycle are a configuration write strobe and the target's done signal. The bench watches the strobes. In the very cycle of the third strobe it raises `cfgDoneIn`, before the next clock edge. It then expects exactly three strobes in total, `configDone` high one cycle later, and no flash access afterwards. The natural end of the byte count is judged the same way: `configDone` must rise in the cycle right after the last strobe, and the strobe count must not grow.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_READ,
    ST_PUSH,
    ST_DONE,
    ST_PROG
  } ldState_t;

  // control -> datapath
  typedef struct packed {
    logic init;
    logic waitRun;
    logic capture;
    logic advance;
    logic countByte;
  } ldStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic waitDone;
    logic syncPhase;
    logic syncOk;
    logic countHit;
  } ldStatus_t;

endpackage

// File: rtl/cfgld_datapath.sv
`timescale 1ns/1ps
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int ADDR_W       = 25,
  parameter int DATA_W       = 8,
  parameter int READ_WAIT    = 8,
  parameter int SYNC_BYTES   = 4,
  parameter logic [SYNC_BYTES*DATA_W-1:0] SYNC_WORD = 'hAA995566,
  parameter int STREAM_BYTES = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              jumperIn,
  input  logic [DATA_W-1:0] flashData,
  input  ldStrobe_t         strb,
  output ldStatus_t         sts,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] cfgData
);

  localparam int OFF_W   = ADDR_W - 1;
  localparam int WAIT_W  = (READ_WAIT > 2) ? $clog2(READ_WAIT) : 1;
  localparam int IDX_W   = (SYNC_BYTES > 2) ? $clog2(SYNC_BYTES) : 1;
  localparam int COUNT_W = $clog2(STREAM_BYTES + 1);

  logic               imageSel;
  logic [OFF_W-1:0]   offset;
  logic [WAIT_W-1:0]  waitCnt;
  logic [DATA_W-1:0]  dataReg;
  logic [COUNT_W-1:0] byteCnt;
  logic [DATA_W-1:0]  syncArr [SYNC_BYTES];
  logic [IDX_W-1:0]   syncIdx;

  // expected sync bytes, most significant byte at offset 0
  for (genvar g = 0; g < SYNC_BYTES; g++) begin : g_sync
    assign syncArr[g] = SYNC_WORD[(SYNC_BYTES-1-g)*DATA_W +: DATA_W];
  end

  assign syncIdx = offset[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imageSel <= 1'b0;
      offset   <= '0;
      waitCnt  <= '0;
      dataReg  <= '0;
      byteCnt  <= '0;
    end else begin
      if (strb.init) begin
        imageSel <= ~jumperIn;
        offset   <= '0;
        byteCnt  <= '0;
      end else begin
        if (strb.advance)   offset  <= offset + 1'b1;
        if (strb.countByte) byteCnt <= byteCnt + 1'b1;
      end
      if (!strb.waitRun || sts.waitDone) waitCnt <= '0;
      else                               waitCnt <= waitCnt + 1'b1;
      if (strb.capture) dataReg <= flashData;
    end
  end

  always_comb begin
    sts.waitDone  = (waitCnt == WAIT_W'(READ_WAIT - 1));
    sts.syncPhase = (offset < OFF_W'(SYNC_BYTES));
    sts.syncOk    = (flashData == syncArr[syncIdx]);
    sts.countHit  = (byteCnt == COUNT_W'(STREAM_BYTES - 1));
  end

  assign flashAddr = {imageSel, offset};
  assign cfgData   = dataReg;

endmodule

// File: rtl/cfgld_control.sv
`timescale 1ns/1ps
module cfgld_control
  import cfgld_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgDoneIn,
  input  ldStatus_t sts,
  output ldStrobe_t strb,
  output logic      flashRead,
  output logic      cfgWrite,
  output logic      configDone,
  output logic      programmingMode
);

  ldState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_INIT;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_INIT: begin
        strb.init = 1'b1;
        stateNxt  = ST_READ;
      end
      ST_READ: begin
        strb.waitRun = 1'b1;
        if (sts.syncPhase) begin
          if (sts.waitDone) begin
            if (sts.syncOk) strb.advance = 1'b1;
            else            stateNxt     = ST_PROG;
          end
        end else if (cfgDoneIn) begin
          stateNxt = ST_DONE;
        end else if (sts.waitDone) begin
          strb.capture = 1'b1;
          stateNxt     = ST_PUSH;
        end
      end
      ST_PUSH: begin
        strb.advance   = 1'b1;
        strb.countByte = 1'b1;
        if (cfgDoneIn || sts.countHit) stateNxt = ST_DONE;
        else                           stateNxt = ST_READ;
      end
      ST_DONE: stateNxt = ST_DONE;
      ST_PROG: stateNxt = ST_PROG;
      default: stateNxt = ST_INIT;
    endcase
  end

  assign flashRead       = (state == ST_READ);
  assign cfgWrite        = (state == ST_PUSH);
  assign configDone      = (state == ST_DONE);
  assign programmingMode = (state == ST_PROG);

endmodule

// File: rtl/cfgld_top.sv
`timescale 1ns/1ps
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int READ_WAIT    = 8,
  parameter int STREAM_BYTES = 2000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        jumperIn,
  output logic [24:0] flashAddr,
  output logic        flashCs,
  output logic        flashOe,
  input  logic [7:0]  flashData,
  output logic [7:0]  cfgData,
  output logic        cfgWrite,
  input  logic        cfgDoneIn,
  output logic        configDone,
  output logic        programmingMode
);

  ldStrobe_t strb;
  ldStatus_t sts;
  logic      flashRead;

  cfgld_control u_ctl (
    .clk             (clk),
    .rstN            (rstN),
    .cfgDoneIn       (cfgDoneIn),
    .sts             (sts),
    .strb            (strb),
    .flashRead       (flashRead),
    .cfgWrite        (cfgWrite),
    .configDone      (configDone),
    .programmingMode (programmingMode)
  );

  cfgld_datapath #(
    .ADDR_W       (25),
    .DATA_W       (8),
    .READ_WAIT    (READ_WAIT),
    .SYNC_BYTES   (4),
    .SYNC_WORD    (32'hAA995566),
    .STREAM_BYTES (STREAM_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .jumperIn  (jumperIn),
    .flashData (flashData),
    .strb      (strb),
    .sts       (sts),
    .flashAddr (flashAddr),
    .cfgData   (cfgData)
  );

  assign flashCs = flashRead;
  assign flashOe = flashRead;

endmodule

// File: rtl/cfgld_checker.sv
`timescale 1ns/1ps
module cfgld_checker (
  input logic        clk,
  input logic        rstN,
  input logic [24:0] flashAddr,
  input logic        flashCs,
  input logic        flashOe,
  input logic        cfgWrite,
  input logic        configDone,
  input logic        programmingMode
);

  AST_NO_READ_DURING_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |-> (!flashCs && !flashOe)); // R7

  AST_IDLE_WHEN_FINISHED: assert property (@(posedge clk) disable iff (!rstN)
    (configDone || programmingMode) |-> (!flashCs && !cfgWrite)); // R7

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !cfgWrite); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (flashAddr[23:0] == 24'($past(flashAddr[23:0]) + 24'd1))); // R4

  AST_IMAGE_BIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (flashCs && $past(flashCs)) |-> $stable(flashAddr[24])); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    configDone |=> configDone); // R8

  AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    programmingMode |=> programmingMode); // R3

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(configDone && programmingMode)); // R3

endmodule

bind cfgld_top cfgld_checker u_cfgld_checker (
  .clk             (clk),
  .rstN            (rstN),
  .flashAddr       (flashAddr),
  .flashCs         (flashCs),
  .flashOe         (flashOe),
  .cfgWrite        (cfgWrite),
  .configDone      (configDone),
  .programmingMode (programmingMode)
);

// File: tb/test_cfgld_top.sv
`timescale 1ns/1ps
module test_cfgld_top;

  localparam int RW = 8;
  localparam int NB = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        jumperIn = 1'b1;
  logic [24:0] flashAddr;
  logic        flashCs, flashOe;
  logic [7:0]  flashData = 8'h00;
  logic [7:0]  cfgData;
  logic        cfgWrite;
  logic        cfgDoneIn = 1'b0;
  logic        configDone, programmingMode;

  int mode = 0;
  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  // monitor records
  bit          seenRead;
  logic [24:0] firstAddr;
  int          firstCyc, csCycles, pinMismatch, csBad, nStrobe, doneCyc;
  logic [7:0]  sData [64];
  logic [24:0] sAddr [64];
  int          sCyc  [64];

  always #5 clk = ~clk;

  cfgld_top #(.READ_WAIT(RW), .STREAM_BYTES(NB)) i_cfgld_top (
    .clk(clk), .rstN(rstN), .jumperIn(jumperIn), .flashAddr(flashAddr),
    .flashCs(flashCs), .flashOe(flashOe), .flashData(flashData),
    .cfgData(cfgData), .cfgWrite(cfgWrite), .cfgDoneIn(cfgDoneIn),
    .configDone(configDone), .programmingMode(programmingMode)
  );

  function automatic logic [7:0] payload(input logic img, input int off);
    return 8'(off * 13 + (img ? 8'h5A : 8'h21));
  endfunction

  function automatic logic [7:0] syncByte(input int off);
    logic [31:0] w = 32'hAA995566;
    return w[(3-off)*8 +: 8];
  endfunction

  function automatic logic [7:0] romByte(input logic img, input int off);
    if (mode == 1) return 8'hFF;
    if (off < 4) begin
      if (mode == 2) return syncByte(3 - off);
      if (mode == 3 && off == 3) return 8'h67;
      return syncByte(off);
    end
    return payload(img, off);
  endfunction

  // synchronous-read flash model
  always @(posedge clk)
    if (flashCs && flashOe) flashData <= romByte(flashAddr[24], int'(flashAddr[23:0]));

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (flashCs && !seenRead) begin seenRead = 1; firstAddr = flashAddr; firstCyc = cyc; end
      if (flashCs) csCycles++;
      if (flashCs != flashOe) pinMismatch++;
      if (flashCs && (configDone || programmingMode || cfgWrite)) csBad++;
      if (cfgWrite) begin
        if (nStrobe < 64) begin
          sData[nStrobe] = cfgData; sAddr[nStrobe] = flashAddr; sCyc[nStrobe] = cyc;
        end
        nStrobe++;
      end
      if (configDone && doneCyc < 0) doneCyc = cyc;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic jmp, input int m);
    @(negedge clk);
    rstN = 1'b0; cfgDoneIn = 1'b0; jumperIn = jmp; mode = m;
    repeat (3) @(negedge clk);
    seenRead = 0; firstAddr = '0; firstCyc = 0; csCycles = 0; pinMismatch = 0;
    csBad = 0; nStrobe = 0; doneCyc = -1;
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "outputs in reset", {cfgWrite, configDone, programmingMode, flashCs, flashOe}, 5'b0);
  endtask

  task automatic testStream(input logic jmp);
    logic img = ~jmp;
    doReset(jmp, 0);
    repeat (5) @(negedge clk);
    jumperIn = ~jmp; // must be ignored, R5
    for (int i = 0; i < 1000 && !configDone; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    #1;
    chk("R1", "first read address", firstAddr, {img, 24'd0});
    chk("R5", "image bit of first read", firstAddr[24], img);
    chk("R8", "strobe count", nStrobe, NB);
    chk("R8", "configDone held", configDone, 1);
    chk("R8", "configDone one cycle after last strobe", doneCyc, sCyc[NB-1] + 1);
    chk("R6", "first strobe delay", sCyc[0] - firstCyc, 5 * RW);
    chk("R6", "read cycles", csCycles, (4 + NB) * RW);
    chk("R7", "chip select overlap", csBad, 0);
    chk("R7", "cs/oe mismatch", pinMismatch, 0);
    chk("R3", "no programming mode", programmingMode, 0);
    for (int i = 0; i < NB; i++) begin
      chk("R4", "byte data", sData[i], payload(img, 4 + i));
      chk("R4", "byte address", sAddr[i], {img, 24'(4 + i)});
      if (i > 0) chk("R6", "strobe spacing", sCyc[i] - sCyc[i-1], RW + 1);
    end
  endtask

  task automatic testBadSync(input int m, input int expCs);
    doReset(1'b1, m);
    repeat (200) @(negedge clk);
    #1;
    chk("R3", "programmingMode", programmingMode, 1);
    chk("R3", "no strobes", nStrobe, 0);
    chk("R3", "read cycles before giving up", csCycles, expCs);
    chk("R2", "no configDone", configDone, 0);
    chk("R7", "no access after mode change", csBad, 0);
    chk("R7", "flashCs idle", flashCs, 0);
  endtask

  task automatic testDoneInput();
    doReset(1'b1, 0);
    for (int i = 0; i < 1000 && nStrobe < 3; i++) begin
      @(negedge clk); #1;
    end
    chk("R9", "strobe seen before done", cfgWrite, 1);
    cfgDoneIn = 1'b1; // same cycle as third strobe
    @(negedge clk); #1;
    chk("R9", "configDone next cycle", configDone, 1);
    cfgDoneIn = 1'b0;
    repeat (40) @(negedge clk);
    #1;
    chk("R9", "strobe count after done", nStrobe, 3);
    chk("R9", "configDone held", configDone, 1);
    chk("R7", "no reads after done", csBad, 0);
    chk("R4", "last data before done", sData[2], payload(1'b0, 6));
  endtask

  initial begin
    #1_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    testResetState();
    testStream(1'b1);   // default image
    testStream(1'b0);   // secondary image
    testBadSync(1, RW);      // blank flash, R3
    testBadSync(2, RW);      // sync bytes reversed, R2
    testBadSync(3, 4 * RW);  // last sync byte wrong, R2
    testDoneInput();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule